// File: doc/BRIEF.md
# Shared Byte RAM with Cross-Side Mailbox Interrupts

This block is a 1 KB byte-addressed memory shared by a host (bus) side and a local processor side. Each side has its own synchronous port and can read or write in every cycle, independently of the other. Reads are registered and return data one cycle after the access.

Two byte locations at the top of the memory serve as mailboxes. When the host writes the processor mailbox (0x3FF), the stored byte is a command code and a level interrupt toward the processor goes high. When the processor writes the host mailbox (0x3FE), an interrupt toward the host goes high. A flag drops when the side it points at accesses its mailbox, by either a read or a write.

The host-owned areas are protected against the processor. These are the bulk command area and the four-byte control-block pointer. Processor writes into them are dropped. The message area, the task/event words, the spare and control bytes and both mailboxes can be written by either side.

Top module: `shared_mailbox_ram`

## Requirements
- R1: Each of the 1024 bytes keeps the last value written to it. A port with its enable high loads its read-data register with the addressed byte one clock later. While the enable is low, the read-data register holds its value.
- R2: When an address is read and written in the same cycle, from either port, the read returns the value the byte held before that write.
- R3: The two ports operate at the same time and independently on different addresses.
- R4: When both ports write the same byte in the same cycle, the host's data is stored.
- R5: A host write to address 0x3FF stores the command byte and drives the processor interrupt high from the next cycle.
- R6: Any processor access to 0x3FF (read or write) clears the processor interrupt. A processor write to 0x3FF never raises it. Host reads of 0x3FF leave it unchanged.
- R7: A processor write to 0x3FE drives the host interrupt high from the next cycle. Any host access to 0x3FE clears it. A host write to 0x3FE does not raise the processor interrupt.
- R8: If a mailbox is set and cleared in the same cycle, the set wins and the interrupt stays high.
- R9: Processor writes to 0x000–0x3DF and 0x3F8–0x3FB are ignored, and the bytes there keep their previous contents.
- R10: Processor writes to 0x3E0–0x3F7 and 0x3FC–0x3FF are stored.
- R11: After reset both interrupts are low and both read-data registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Active-low synchronous reset |
| hostEn | input | 1 | Host access enable |
| hostWe | input | 1 | Host write enable (valid with hostEn) |
| hostAddr | input | 10 | Host byte address |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host registered read data |
| cpuEn | input | 1 | Processor access enable |
| cpuWe | input | 1 | Processor write enable (valid with cpuEn) |
| cpuAddr | input | 10 | Processor byte address |
| cpuWdata | input | 8 | Processor write data |
| cpuRdata | output | 8 | Processor registered read data |
| cpuIrq | output | 1 | Interrupt toward the processor (level) |
| hostIrq | output | 1 | Interrupt toward the host (level) |

## Verification
The bench uses the default parameters: a 10-bit address giving 1024 bytes, the mailboxes at 0x3FF and 0x3FE, and two protected regions. With these values every byte can be filled and read back inside the run. Random traffic is aimed at the top 32 bytes half of the time. That makes same-address collisions, mailbox set/clear races and writes on both sides of the protected-region edges common enough to be hit many times in the random phase.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Per-cycle strobes that the control hands to the datapath
  typedef struct packed {
    logic hostWr;   // commit host write this cycle
    logic cpuWr;    // commit processor write (already permission/collision filtered)
    logic hostRd;   // capture host read data
    logic cpuRd;    // capture processor read data
  } dpStrobes_t;

endpackage

// File: rtl/mbox_irq_flag.sv
// Level interrupt flag: set has priority over clear.
module mbox_irq_flag (
  input  logic clk,
  input  logic rstN,
  input  logic setReq,
  input  logic clrReq,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rstN)       flag <= 1'b0;
    else if (setReq) flag <= 1'b1;
    else if (clrReq) flag <= 1'b0;
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NUM_PROT = 2,
  parameter logic [ADDR_W-1:0] CPU_MBOX  = 10'h3FF,
  parameter logic [ADDR_W-1:0] HOST_MBOX = 10'h3FE,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LO = {10'h3F8, 10'h000},
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_HI = {10'h3FB, 10'h3DF}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              cpuEn,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  output dpStrobes_t        strobes,
  output logic              cpuIrq,
  output logic              hostIrq
);

  // Protected-region decode for the processor address, one comparator per region.
  // Offset-from-base form keeps a zero base from becoming a constant compare.
  logic [NUM_PROT-1:0] inRegion;
  for (genvar g = 0; g < NUM_PROT; g++) begin : g_prot
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] span;
    assign offs        = cpuAddr - PROT_LO[g*ADDR_W +: ADDR_W];
    assign span        = PROT_HI[g*ADDR_W +: ADDR_W] - PROT_LO[g*ADDR_W +: ADDR_W];
    assign inRegion[g] = (offs <= span);
  end

  logic cpuProtected;
  logic hostWrite;
  logic cpuWriteReq;
  logic sameAddr;
  logic cpuWriteOk;

  assign cpuProtected = |inRegion;
  assign hostWrite    = hostEn & hostWe;
  assign cpuWriteReq  = cpuEn & cpuWe;
  assign sameAddr     = (hostAddr == cpuAddr);
  // Host wins collisions; protected bytes never take processor data
  assign cpuWriteOk   = cpuWriteReq & ~cpuProtected & ~(hostWrite & sameAddr);

  always_comb begin
    strobes.hostWr = hostWrite;
    strobes.cpuWr  = cpuWriteOk;
    strobes.hostRd = hostEn;
    strobes.cpuRd  = cpuEn;
  end

  // Mailbox events
  logic cpuMboxSet;
  logic cpuMboxClr;
  logic hostMboxSet;
  logic hostMboxClr;

  assign cpuMboxSet  = hostWrite & (hostAddr == CPU_MBOX);
  assign cpuMboxClr  = cpuEn & (cpuAddr == CPU_MBOX);
  // Raised on a processor write request to the host mailbox, even if the host
  // overwrote the byte in the same cycle.
  assign hostMboxSet = cpuWriteReq & ~cpuProtected & (cpuAddr == HOST_MBOX);
  assign hostMboxClr = hostEn & (hostAddr == HOST_MBOX);

  mbox_irq_flag u_cpuFlag (
    .clk    (clk),
    .rstN   (rstN),
    .setReq (cpuMboxSet),
    .clrReq (cpuMboxClr),
    .flag   (cpuIrq)
  );

  mbox_irq_flag u_hostFlag (
    .clk    (clk),
    .rstN   (rstN),
    .setReq (hostMboxSet),
    .clrReq (hostMboxClr),
    .flag   (hostIrq)
  );

endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage: both write ports; control guarantees no same-address double write
  always_ff @(posedge clk) begin
    if (strobes.cpuWr)  mem[cpuAddr]  <= cpuWdata;
    if (strobes.hostWr) mem[hostAddr] <= hostWdata;
  end

  // Registered reads, old data on same-cycle write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdata <= '0;
      cpuRdata  <= '0;
    end else begin
      if (strobes.hostRd) hostRdata <= mem[hostAddr];
      if (strobes.cpuRd)  cpuRdata  <= mem[cpuAddr];
    end
  end

endmodule

// File: rtl/shared_mailbox_ram.sv
module shared_mailbox_ram
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int NUM_PROT = 2,
  parameter logic [ADDR_W-1:0] CPU_MBOX  = 10'h3FF,
  parameter logic [ADDR_W-1:0] HOST_MBOX = 10'h3FE,
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LO = {10'h3F8, 10'h000},
  parameter logic [NUM_PROT*ADDR_W-1:0] PROT_HI = {10'h3FB, 10'h3DF}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              cpuEn,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuIrq,
  output logic              hostIrq
);

  dpStrobes_t strobes;

  mbox_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_PROT  (NUM_PROT),
    .CPU_MBOX  (CPU_MBOX),
    .HOST_MBOX (HOST_MBOX),
    .PROT_LO   (PROT_LO),
    .PROT_HI   (PROT_HI)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostEn   (hostEn),
    .hostWe   (hostWe),
    .hostAddr (hostAddr),
    .cpuEn    (cpuEn),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .strobes  (strobes),
    .cpuIrq   (cpuIrq),
    .hostIrq  (hostIrq)
  );

  mbox_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .hostRdata (hostRdata),
    .cpuRdata  (cpuRdata)
  );

endmodule

// File: rtl/shared_mailbox_ram_chk.sv
module shared_mailbox_ram_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CPU_MBOX  = 10'h3FF,
  parameter logic [ADDR_W-1:0] HOST_MBOX = 10'h3FE
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostEn,
  input logic              hostWe,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostRdata,
  input logic              cpuEn,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [DATA_W-1:0] cpuRdata,
  input logic              cpuIrq,
  input logic              hostIrq
);

  logic hostHitsCpuBox;
  logic cpuWritesHostBox;
  assign hostHitsCpuBox   = hostEn & hostWe & (hostAddr == CPU_MBOX);
  assign cpuWritesHostBox = cpuEn & cpuWe & (cpuAddr == HOST_MBOX);

  p_cpu_irq_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    hostHitsCpuBox |=> cpuIrq);

  p_cpu_irq_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuEn && cpuAddr == CPU_MBOX && !hostHitsCpuBox) |=> !cpuIrq);

  p_cpu_irq_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuIrq) |-> $past(hostHitsCpuBox));

  p_host_irq_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuWritesHostBox |=> hostIrq);

  p_host_irq_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostEn && hostAddr == HOST_MBOX && !cpuWritesHostBox) |=> !hostIrq);

  p_host_irq_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(cpuWritesHostBox));

  p_host_rd_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !hostEn |=> $stable(hostRdata));

  p_cpu_rd_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cpuEn |=> $stable(cpuRdata));

endmodule

bind shared_mailbox_ram shared_mailbox_ram_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CPU_MBOX  (CPU_MBOX),
  .HOST_MBOX (HOST_MBOX)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostEn    (hostEn),
  .hostWe    (hostWe),
  .hostAddr  (hostAddr),
  .hostRdata (hostRdata),
  .cpuEn     (cpuEn),
  .cpuWe     (cpuWe),
  .cpuAddr   (cpuAddr),
  .cpuRdata  (cpuRdata),
  .cpuIrq    (cpuIrq),
  .hostIrq   (hostIrq)
);

// File: tb/shared_mailbox_ram_bench.sv
`timescale 1ns/1ps
module shared_mailbox_ram_bench;

  localparam logic [9:0] CPU_BOX  = 10'h3FF;
  localparam logic [9:0] HOST_BOX = 10'h3FE;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostEn = 0, hostWe = 0, cpuEn = 0, cpuWe = 0;
  logic [9:0] hostAddr = '0, cpuAddr = '0;
  logic [7:0] hostWdata = '0, cpuWdata = '0;
  logic [7:0] hostRdata, cpuRdata;
  logic       cpuIrq, hostIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;   // 50 MHz

  shared_mailbox_ram u_shared_mailbox_ram (
    .clk(clk), .rstN(rstN),
    .hostEn(hostEn), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .cpuEn(cpuEn), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuIrq(cpuIrq), .hostIrq(hostIrq)
  );

  // Reference model state
  logic [7:0] expMem [1024];
  logic [7:0] expHostRd = '0, expCpuRd = '0;
  logic       expCpuIrq = 0, expHostIrq = 0;

  function automatic bit isProt(logic [9:0] a);
    return (a <= 10'h3DF) || (a >= 10'h3F8 && a <= 10'h3FB);
  endfunction

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drives one cycle (entered at a negedge), advances model, checks at next negedge
  task automatic step(string tag,
                      logic hE, logic hW, logic [9:0] hA, logic [7:0] hD,
                      logic cE, logic cW, logic [9:0] cA, logic [7:0] cD);
    logic hWr, cWrOk, cSet, cClr, hSet, hClr;
    hostEn = hE; hostWe = hW; hostAddr = hA; hostWdata = hD;
    cpuEn  = cE; cpuWe  = cW; cpuAddr  = cA; cpuWdata  = cD;
    hWr   = hE & hW;
    cWrOk = cE & cW & !isProt(cA) & !(hWr && hA == cA);
    if (hE) expHostRd = expMem[hA];
    if (cE) expCpuRd  = expMem[cA];
    cSet = hWr && hA == CPU_BOX;
    cClr = cE && cA == CPU_BOX;
    hSet = cE && cW && !isProt(cA) && cA == HOST_BOX;
    hClr = hE && hA == HOST_BOX;
    expCpuIrq  = cSet | (expCpuIrq & !cClr);
    expHostIrq = hSet | (expHostIrq & !hClr);
    if (cWrOk) expMem[cA] = cD;
    if (hWr)   expMem[hA] = hD;
    @(posedge clk);
    @(negedge clk);
    hostEn = 0; cpuEn = 0; hostWe = 0; cpuWe = 0;
    chk(tag, "hostRdata", hostRdata, expHostRd);
    chk(tag, "cpuRdata",  cpuRdata,  expCpuRd);
    chk(tag, "cpuIrq",    {7'd0, cpuIrq},  {7'd0, expCpuIrq});
    chk(tag, "hostIrq",   {7'd0, hostIrq}, {7'd0, expHostIrq});
  endtask

  task automatic hostWr(string tag, logic [9:0] a, logic [7:0] d);
    step(tag, 1, 1, a, d, 0, 0, '0, '0);
  endtask
  task automatic hostRd(string tag, logic [9:0] a);
    step(tag, 1, 0, a, '0, 0, 0, '0, '0);
  endtask
  task automatic cpuWr(string tag, logic [9:0] a, logic [7:0] d);
    step(tag, 0, 0, '0, '0, 1, 1, a, d);
  endtask
  task automatic cpuRd(string tag, logic [9:0] a);
    step(tag, 0, 0, '0, '0, 1, 0, a, '0);
  endtask

  function automatic logic [9:0] randAddr();
    if ($urandom_range(1) == 0) return 10'($urandom_range(1023));
    return 10'h3E0 + 10'($urandom_range(31));
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired before completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "hostRdata", hostRdata, 8'h00);
    chk("R11", "cpuRdata",  cpuRdata,  8'h00);
    chk("R11", "cpuIrq",    {7'd0, cpuIrq},  8'h00);
    chk("R11", "hostIrq",   {7'd0, hostIrq}, 8'h00);
    rstN = 1'b1;

    // R1: fill every byte from the host side
    for (int i = 0; i < 1024; i++) hostWr("R1", 10'(i), 8'(i * 7 + 3));
    cpuRd("R6", CPU_BOX);   // clears interrupt raised by the fill
    // R3: both ports read back simultaneously
    for (int i = 0; i < 512; i++)
      step("R3", 1, 0, 10'(i), '0, 1, 0, 10'(1023 - i), '0);
    // R1: hold while idle
    step("R1", 0, 0, '0, '0, 0, 0, '0, '0);

    // R2: read old data during same-cycle write (cross-port and same-port)
    step("R2", 1, 1, 10'h3E4, 8'hA5, 1, 0, 10'h3E4, '0);
    step("R2", 1, 0, 10'h3E8, '0, 1, 1, 10'h3E8, 8'h5A);
    step("R2", 1, 1, 10'h100, 8'h11, 0, 0, '0, '0);
    cpuRd("R2", 10'h3E8);

    // R4: collision, host wins
    step("R4", 1, 1, 10'h3F0, 8'hC3, 1, 1, 10'h3F0, 8'h3C);
    cpuRd("R4", 10'h3F0);

    // R5: command to processor mailbox
    hostWr("R5", CPU_BOX, 8'h02);
    cpuRd("R5", CPU_BOX);          // returns command, clears
    // R6: processor acknowledge write does not raise; host read does not clear
    cpuWr("R6", CPU_BOX, 8'hFE);
    hostRd("R6", CPU_BOX);
    hostWr("R6", CPU_BOX, 8'h09);
    hostRd("R6", CPU_BOX);
    cpuWr("R6", CPU_BOX, 8'hFE);   // write access clears

    // R7: host mailbox
    cpuWr("R7", HOST_BOX, 8'h44);
    hostRd("R7", HOST_BOX);
    cpuWr("R7", HOST_BOX, 8'h45);
    hostWr("R7", HOST_BOX, 8'h00); // write access clears, no processor irq

    // R8: set and clear in the same cycle
    step("R8", 1, 1, CPU_BOX, 8'h07, 1, 0, CPU_BOX, '0);
    step("R8", 1, 0, HOST_BOX, '0, 1, 1, HOST_BOX, 8'h21);
    hostRd("R8", HOST_BOX);
    cpuRd("R8", CPU_BOX);

    // R9: protected regions, edges included
    cpuWr("R9", 10'h000, 8'hEE);
    cpuWr("R9", 10'h3DF, 8'hEE);
    cpuWr("R9", 10'h3F8, 8'hEE);
    cpuWr("R9", 10'h3FB, 8'hEE);
    hostRd("R9", 10'h000);
    hostRd("R9", 10'h3DF);
    hostRd("R9", 10'h3F8);
    hostRd("R9", 10'h3FB);

    // R10: writable areas, edges included
    cpuWr("R10", 10'h3E0, 8'h81);
    cpuWr("R10", 10'h3F7, 8'h82);
    cpuWr("R10", 10'h3FC, 8'h83);
    cpuWr("R10", 10'h3FD, 8'h84);
    hostRd("R10", 10'h3E0);
    hostRd("R10", 10'h3F7);
    hostRd("R10", 10'h3FC);
    hostRd("R10", 10'h3FD);

    // R3: constrained random traffic on both ports
    for (int i = 0; i < 4000; i++)
      step("R3",
           $urandom_range(3) != 0, 1'($urandom_range(1)), randAddr(), 8'($urandom),
           $urandom_range(3) != 0, 1'($urandom_range(1)), randAddr(), 8'($urandom));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule